// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss by fetching one page table entry from memory. The translation buffer hands it a 20-bit virtual page number and tells it whether the access is a read or a write. The walker adds four times that page number to the current process's table base and issues a single 32-bit read on a simple memory request/response port. It then decodes the returned entry.

A valid entry yields the physical page number and the updated status flags. The in-memory entry keeps its reference and dirty bits current. The walker writes the entry back only when one of those bits actually changes. An invalid entry produces a page fault. A write to a read-only page produces a protection fault. Neither fault writes anything to memory.

The table base is a register held inside the walker. It is reloaded through a load strobe on a context switch. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The entry read is issued at byte address `base + vpn*4` (32-bit wrap-around). `base` is the value of the table base register when the request is accepted.
- R2: The table base register resets to 0. A `base_load` pulse stores `base_value`, and the new value applies to requests accepted in later cycles.
- R3: `req_ready` is high only while idle. It is low from the cycle after a request is accepted until the response handshake (`rsp_valid && rsp_ready`) completes.
- R4: Entry layout: bit 0 valid, bit 1 reference, bit 2 dirty, bit 3 writable, bits 31:12 physical page number. If bit 0 is 0, the response has `rsp_status` = 2'b01 (page fault), `rsp_ppn` = 0 and `rsp_flags` = 0, and no write is issued.
- R5: For a read access to a valid entry, the response has `rsp_status` = 2'b00 and `rsp_ppn` = entry bits 31:12. The updated entry is the fetched entry with bit 1 set.
- R6: For a write access to a valid entry with bit 3 set, the response has `rsp_status` = 2'b00. The updated entry is the fetched entry with bits 1 and 2 set.
- R7: For a write access to a valid entry with bit 3 clear, the response has `rsp_status` = 2'b10 (protection fault), `rsp_ppn` = 0 and `rsp_flags` = 0, and no write is issued.
- R8: When the updated entry differs from the fetched entry, exactly one write of the updated entry to the same address is issued before the response. When it does not differ, no write is issued.
- R9: On a successful walk, `rsp_flags` = {writable, dirty, reference} of the updated entry.
- R10: A memory request holds its address, data and direction until `mem_req_ready`. A response holds all its fields until `rsp_ready`.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_load | input | 1 | Load strobe for the table base register |
| base_value | input | 32 | New table base byte address |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_vpn | input | 20 | Virtual page number that missed |
| req_is_write | input | 1 | Access that missed is a write |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write of entry, 0 = read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per read) |
| mem_rsp_rdata | input | 32 | Fetched entry |
| rsp_valid | output | 1 | Walk result valid |
| rsp_ready | input | 1 | Translation buffer takes the result |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_ppn | output | 20 | Physical page number |
| rsp_flags | output | 3 | {writable, dirty, reference} |

## Verification
The bench targets a write to a read-only page. A walker that ignored the writable bit would return a translation and mark a read-only page dirty in memory. It also repeats accesses to entries that are already referenced or dirty. There, a walker that always wrote back would show extra memory writes, and one that never wrote back would leave stale bits in memory. Invalid entries check that a fault leaves memory untouched and reports zeros. A base reload followed by a walk at the largest page number catches a stale base or a mis-scaled index. Random stalls on the memory handshake and on the response handshake catch results that change before they are taken and a ready that rises early.

// File: rtl/pt_walker_pkg.sv
// Shared types and entry bit positions for the page table walker.
// Assumes a 32-bit entry; field positions are fixed by the table format.
package pt_walker_pkg;
    localparam int unsigned PTE_VALID_BIT = 0;
    localparam int unsigned PTE_REF_BIT   = 1;
    localparam int unsigned PTE_DIRTY_BIT = 2;
    localparam int unsigned PTE_WR_BIT    = 3;

    typedef enum logic [1:0] {
        ST_OK        = 2'b00,
        ST_PAGE_FLT  = 2'b01,
        ST_PROT_FLT  = 2'b10
    } walk_status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_WAIT, S_EVAL, S_WB, S_RSP
    } walk_state_e;
endpackage

// File: rtl/pt_entry_addr.sv
// Entry address generator: base plus page number scaled by entry size.
// Assumes entry size is a power of two; the sum wraps at ADDR_W bits.
module pt_entry_addr #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned VPN_W     = 20,
    parameter int unsigned PTE_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int unsigned SHIFT = $clog2(PTE_BYTES);

    logic [ADDR_W-1:0] scaled;

    // Scale the page number into a byte offset and add the base.
    always_comb begin
        scaled     = ADDR_W'(vpn) << SHIFT;
        entry_addr = base + scaled;
    end
endmodule

// File: rtl/pt_entry_eval.sv
// Entry evaluator: classifies a fetched entry and forms the updated word.
// Purely combinational; assumes entry field positions from pt_walker_pkg.
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int unsigned PTE_W     = 32,
    parameter int unsigned PAGE_BITS = 12,
    localparam int unsigned PPN_W    = PTE_W - PAGE_BITS
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output logic [PTE_W-1:0] new_pte,
    output logic             need_wb,
    output walk_status_e     status,
    output logic [PPN_W-1:0] ppn,
    output logic [2:0]       flags
);
    // Decide outcome, set usage bits and report fields.
    always_comb begin
        new_pte = pte;
        new_pte[PTE_REF_BIT] = 1'b1;
        if (is_write) new_pte[PTE_DIRTY_BIT] = 1'b1;
        if (!pte[PTE_VALID_BIT])                 status = ST_PAGE_FLT;
        else if (is_write && !pte[PTE_WR_BIT])   status = ST_PROT_FLT;
        else                                     status = ST_OK;
        need_wb = (status == ST_OK) && (new_pte != pte);
        if (status == ST_OK) begin
            ppn   = new_pte[PTE_W-1:PAGE_BITS];
            flags = {new_pte[PTE_WR_BIT], new_pte[PTE_DIRTY_BIT], new_pte[PTE_REF_BIT]};
        end else begin
            ppn   = '0;
            flags = '0;
        end
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer: accept, read entry, evaluate, optional write-back, respond.
// Assumes exactly one read-data pulse per accepted read; writes complete on accept.
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PTE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_write,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PTE_W-1:0]  pte_q,
    output logic              write_q,
    input  logic [PTE_W-1:0]  new_pte,
    input  logic              need_wb
);
    walk_state_e       state;
    logic [ADDR_W-1:0] addr_q;

    // Walk state machine and captured request/entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            write_q <= 1'b0;
            pte_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    addr_q  <= entry_addr;
                    write_q <= req_is_write;
                    state   <= S_RD;
                end
                S_RD:   if (mem_req_ready) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    pte_q <= mem_rsp_rdata;
                    state <= S_EVAL;
                end
                S_EVAL: state <= need_wb ? S_WB : S_RSP;
                S_WB:   if (mem_req_ready) state <= S_RSP;
                S_RSP:  if (rsp_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from state.
    always_comb begin
        req_ready     = (state == S_IDLE);
        mem_req_valid = (state == S_RD) || (state == S_WB);
        mem_req_write = (state == S_WB);
        mem_req_addr  = addr_q;
        mem_req_wdata = (state == S_WB) ? new_pte : '0;
        rsp_valid     = (state == S_RSP);
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));
    // R3
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    // R3
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready);
    // R4
    wb_valid_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[PTE_VALID_BIT]
            && mem_req_wdata[PTE_REF_BIT]);
    // R8
    wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_addr == addr_q && $stable(addr_q));
endmodule

// File: rtl/pt_walker.sv
// Single-level page table walker top: base register, address, sequencer, evaluator.
// Assumes one walk at a time and a memory port with in-order single read responses.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PTE_W     = 32,
    parameter int unsigned PTE_BYTES = 4,
    localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
    localparam int unsigned PPN_W    = PTE_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_value,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic              req_is_write,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [2:0]        rsp_flags
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] entry_addr;
    logic [PTE_W-1:0]  pte_q;
    logic [PTE_W-1:0]  new_pte;
    logic              write_q;
    logic              need_wb;
    walk_status_e      status;

    // Per-process table base, reloaded on context switch.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (base_load) base_q <= base_value;
    end

    pt_entry_addr #(.ADDR_W(ADDR_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)) u_addr (
        .base(base_q), .vpn(req_vpn), .entry_addr(entry_addr)
    );

    pt_walk_ctrl #(.ADDR_W(ADDR_W), .PTE_W(PTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
        .entry_addr(entry_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .pte_q(pte_q), .write_q(write_q), .new_pte(new_pte), .need_wb(need_wb)
    );

    pt_entry_eval #(.PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS)) u_eval (
        .pte(pte_q), .is_write(write_q), .new_pte(new_pte), .need_wb(need_wb),
        .status(status), .ppn(rsp_ppn), .flags(rsp_flags)
    );

    assign rsp_status = status;

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status)
            && $stable(rsp_ppn) && $stable(rsp_flags));
    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status != 2'b00 |-> rsp_ppn == '0 && rsp_flags == 3'b000);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_load = 1'b0;
    logic [31:0] base_value = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic        req_is_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [19:0] rsp_ppn;
    logic [2:0]  rsp_flags;

    pt_walker u_dut (.*);

    always #2 clk = ~clk;

    logic [31:0] pt_mem [bit [31:0]];
    int unsigned n_checks = 0, n_fail = 0;
    int unsigned n_reads = 0, n_writes = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] model_base = '0;
    bit          done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (pt_mem.exists(a)) return pt_mem[a];
        return 32'h0;
    endfunction

    function automatic logic [1:0] exp_status(input logic [31:0] e, input logic wr);
        if (!e[0]) return 2'b01;
        if (wr && !e[3]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_update(input logic [31:0] e, input logic wr);
        logic [31:0] u = e | 32'h2;
        if (wr) u = u | 32'h4;
        return u;
    endfunction

    // Behavioural memory: random accept stalls, random read latency.
    initial begin
        bit pend = 0;
        int dly = 0;
        logic [31:0] pdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = pdata;
                    pend = 0;
                end else dly--;
            end
            mem_req_ready = ($urandom % 3) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    pt_mem[mem_req_addr] = mem_req_wdata;
                    n_writes++;
                end else begin
                    last_rd_addr = mem_req_addr;
                    pdata = rd_mem(mem_req_addr);
                    dly = $urandom % 4;
                    pend = 1;
                    n_reads++;
                end
            end
        end
    end

    task automatic load_base(input logic [31:0] b);
        @(negedge clk);
        base_load = 1'b1; base_value = b;
        @(negedge clk);
        base_load = 1'b0;
        model_base = b;
    endtask

    task automatic walk(input logic [19:0] vpn, input logic wr);
        logic [31:0] addr = model_base + {10'd0, vpn, 2'b00};
        logic [31:0] e = rd_mem(addr);
        logic [1:0]  st = exp_status(e, wr);
        logic [31:0] u = exp_update(e, wr);
        bit          wb = (st == 2'b00) && (u != e);
        int unsigned w0, r0, busy_hi = 0;
        bit          got = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_is_write = wr;
        w0 = n_writes; r0 = n_reads;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got) begin
            if (req_ready) busy_hi++;
            if (rsp_valid) begin
                rsp_ready = ($urandom % 2) != 0;
                if (rsp_ready) begin
                    got = 1;
                    check("R4/R5/R6/R7 status", {30'd0, rsp_status}, {30'd0, st});
                    check("R5 ppn", {12'd0, rsp_ppn}, st == 2'b00 ? {12'd0, u[31:12]} : 32'd0);
                    check("R9 flags", {29'd0, rsp_flags},
                          st == 2'b00 ? {29'd0, u[3], u[2], u[1]} : 32'd0);
                end
            end
            @(negedge clk);
            rsp_ready = 1'b0;
        end
        check("R3 ready low while busy", busy_hi, 0);
        check("R3 ready back after response", {31'd0, req_ready}, 1);
        check("R1 entry address", last_rd_addr, addr);
        check("R1 one read", n_reads - r0, 1);
        check("R8 write count", n_writes - w0, wb ? 1 : 0);
        check("R8 memory entry", rd_mem(addr), wb ? u : e);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 24; i++) begin
            logic [31:0] ra = $urandom;
            pt_mem[32'h0040_0000 + 32'h400 + 4 * i] =
                {ra[31:12], 8'h00, ra[3:1], ((ra[5:4] != 0) ? 1'b1 : 1'b0)};
            ra = $urandom;
            pt_mem[32'h0080_0000 + 32'h400 + 4 * i] =
                {ra[31:12], 8'h00, ra[3:1], ((ra[5:4] != 0) ? 1'b1 : 1'b0)};
        end
        // directed entries at base 0x0040_0000
        pt_mem[32'h0040_0000 + 4 * 1] = 32'hABCDE_000 | 32'h1;   // valid, read-only
        pt_mem[32'h0040_0000 + 4 * 2] = 32'h12345_000 | 32'hF;   // all bits set
        pt_mem[32'h0040_0000 + 4 * 3] = 32'h55555_000;           // invalid
        pt_mem[32'h0100_0000 + 32'h3F_FFFC] = 32'hFEDCB_000 | 32'h9;

        repeat (3) @(negedge clk);
        check("R11 req_ready", {31'd0, req_ready}, 1);
        check("R11 rsp_valid", {31'd0, rsp_valid}, 0);
        check("R11 mem_req_valid", {31'd0, mem_req_valid}, 0);
        rst_n = 1'b1;

        // R2: reset base is zero; unmapped vpn reads address 4*vpn and faults
        walk(20'h00010, 1'b0);
        load_base(32'h0040_0000);
        walk(20'd1, 1'b1);   // R7 protection fault, no write
        walk(20'd1, 1'b0);   // R5 sets reference, one write
        walk(20'd1, 1'b0);   // R8 already referenced, no write
        walk(20'd2, 1'b1);   // R8 all set, no write
        walk(20'd3, 1'b1);   // R4 invalid
        load_base(32'h0100_0000);
        walk(20'hFFFFF, 1'b1); // R1 largest vpn, R6 set ref+dirty

        for (int k = 0; k < 300; k++) begin
            if ($urandom % 16 == 0)
                load_base(($urandom % 2) ? 32'h0040_0000 : 32'h0080_0000);
            walk(20'h00100 + 20'($urandom % 24), 1'($urandom % 2));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule